// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block runs Clause 45 management frames on the two-wire MDC/MDIO bus, under control of four small memory-mapped registers. Software first writes a control word that selects the target port and device. After that, a single register write starts each kind of frame:

- writing the address register sends an address frame carrying the register number;
- writing the data register sends a write frame carrying the low 16 bits;
- writing the control word with its read flag set sends a read frame. The 16 bits returned by the PHY are placed in the data register.

A shared status word reports busy and the read error flag. The same word also holds the MDC divider and seven configuration bits. Software polls busy before it issues the next access.

The block has three parts:

- **Register file.** Decodes each write and rejects it while a frame is running.
- **Clock generator.** Divides the system clock down to MDC.
- **Frame engine.** Walks the states IDLE, PRE, HDR, TA, DATA and END. Its transitions are:
  - IDLE→PRE on an accepted start;
  - PRE→HDR after the last preamble bit;
  - HDR→TA after 14 header bits;
  - TA→DATA after two turnaround bits;
  - DATA→END after 16 data bits;
  - END→IDLE on the following falling edge of MDC, which leaves MDC low.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset the status word (offset 3) reads DIV_RST at bits [7+:DIV_W] and 0x48 at bits 6:0, with busy (bit 31) and error (bit 30) clear. With the defaults this is 0x00000A48. MDC and mdio_oe are low.
- R2: The control word (offset 0) holds the device in bits 4:0, the port in bits 9:5 and the read flag in bit 15. It reads back as written in bits 15:0. A write with bit 15 clear starts no frame.
- R3: Writing the address register (offset 1) sends the following frame, MSB first: PRE_LEN ones, ST 00, opcode 00, port, device, turnaround 10, then the 16-bit value. The master drives every bit of this frame.
- R4: Writing the data register (offset 2) sends the same frame with opcode 01, carrying the low 16 bits of the write. The data register then reads back that value.
- R5: Writing the control word with bit 15 set sends opcode 11. The master drives up to the device field, then releases MDIO (mdio_oe low) from the first turnaround bit to the end of the frame.
- R6: At the end of a read frame, the 16 bits sampled from the PHY, MSB first, appear in data register bits 15:0, and bits 31:16 read zero.
- R7: If the PHY leaves the second turnaround bit of a read frame high, error bit 30 is set. Any accepted start clears it.
- R8: Busy (bit 31) reads 1 from the cycle after a frame is started until the frame ends. After the frame ends, MDC and mdio_oe are low.
- R9: Each MDC phase lasts N system clocks, where N is the divider field, and a value of 0 is treated as 1. MDIO changes only together with a rising edge of MDC.
- R10: Any register write that arrives while busy is set is ignored. The running frame continues unchanged, and no register contents change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset (0 control, 1 address, 2 data, 3 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at reg_addr |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO level seen at the pin |
| mdio_o | output | 1 | MDIO level driven by the master |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The bench builds the block with PRE_LEN of 8, DIV_W of 8 and DIV_RST of 20. The short preamble keeps each frame to 40 bits, so a full sweep fits in a short run. The sweep covers divider values 0 through 3 against all three opcodes, with a different port, device and value in each frame. This reaches:

- the rule that maps a divider of 0 to 1;
- every bit of the frame, captured at MDC rising edges;
- a turnaround error;
- writes that arrive in the middle of a frame.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b11
    } op_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_HDR,
        S_TA,
        S_DATA,
        S_END
    } frm_state_t;

    localparam int HDR_BITS  = 14;
    localparam int TA_BITS   = 2;
    localparam int DATA_BITS = 16;
    localparam int SR_W      = HDR_BITS + TA_BITS + DATA_BITS;

    localparam logic [1:0] RA_CMD  = 2'd0;
    localparam logic [1:0] RA_ADDR = 2'd1;
    localparam logic [1:0] RA_DATA = 2'd2;
    localparam logic [1:0] RA_STAT = 2'd3;

    localparam logic [6:0] CFG_RST = 7'h48;

endpackage

// File: rtl/mdio_c45_clkgen.sv
module mdio_c45_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             mdc_o,
    output logic             rise_o,
    output logic             fall_o
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] half_m1;
    logic             wrap;

    assign half_m1 = (half_i == '0) ? '0 : half_i - 1'b1;
    assign wrap    = run_i && (cnt_q >= half_m1);
    assign rise_o  = wrap && !mdc_o;
    assign fall_o  = wrap && mdc_o;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_o <= 1'b0;
        end else if (!run_i) begin
            cnt_q <= '0;
            mdc_o <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_o <= !mdc_o;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !mdc_o);

    // R9
    phase_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q <= half_m1));

endmodule

// File: rtl/mdio_c45_frame.sv
module mdio_c45_frame
    import mdio_c45_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  op_t                  op_i,
    input  logic [4:0]           port_i,
    input  logic [4:0]           dev_i,
    input  logic [15:0]          field_i,
    input  logic                 rise_i,
    input  logic                 fall_i,
    input  logic                 mdio_i,
    output logic                 busy_o,
    output logic                 mdio_o,
    output logic                 mdio_oe_o,
    output logic                 rd_done_o,
    output logic [DATA_BITS-1:0] rd_data_o,
    output logic                 ta_err_o
);

    localparam int CNT_W = $clog2(PRE_LEN + DATA_BITS + 1);

    frm_state_t           state_q, state_d;
    logic [CNT_W-1:0]     cnt_q, cnt_d;
    logic [SR_W-1:0]      sr_q, sr_d;
    logic                 rd_q, rd_d;
    logic [DATA_BITS-2:0] rx_q, rx_d;
    logic                 last_bit;

    assign last_bit = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            sr_q    <= '0;
            rd_q    <= 1'b0;
            rx_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sr_q    <= sr_d;
            rd_q    <= rd_d;
            rx_q    <= rx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        sr_d    = sr_q;
        rd_d    = rd_q;
        rx_d    = rx_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    state_d = S_PRE;
                    cnt_d   = CNT_W'(PRE_LEN - 1);
                    sr_d    = {2'b00, op_i, port_i, dev_i, 2'b10, field_i};
                    rd_d    = (op_i == OP_READ);
                end
            end
            S_PRE: begin
                if (rise_i) begin
                    if (last_bit) begin
                        state_d = S_HDR;
                        cnt_d   = CNT_W'(HDR_BITS - 1);
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            S_HDR: begin
                if (rise_i) begin
                    sr_d = {sr_q[SR_W-2:0], 1'b0};
                    if (last_bit) begin
                        state_d = S_TA;
                        cnt_d   = CNT_W'(TA_BITS - 1);
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            S_TA: begin
                if (rise_i) begin
                    sr_d = {sr_q[SR_W-2:0], 1'b0};
                    if (last_bit) begin
                        state_d = S_DATA;
                        cnt_d   = CNT_W'(DATA_BITS - 1);
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            S_DATA: begin
                if (rise_i) begin
                    sr_d = {sr_q[SR_W-2:0], 1'b0};
                    rx_d = {rx_q[DATA_BITS-3:0], mdio_i};
                    if (last_bit) begin
                        state_d = S_END;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            S_END: begin
                if (fall_i) begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        busy_o    = 1'b1;
        mdio_o    = 1'b1;
        mdio_oe_o = 1'b0;
        rd_done_o = 1'b0;
        ta_err_o  = 1'b0;
        rd_data_o = {rx_q, mdio_i};
        unique case (state_q)
            S_IDLE: busy_o = 1'b0;
            S_PRE:  mdio_oe_o = 1'b1;
            S_HDR: begin
                mdio_o    = sr_q[SR_W-1];
                mdio_oe_o = 1'b1;
            end
            S_TA: begin
                mdio_o    = sr_q[SR_W-1];
                mdio_oe_o = !rd_q;
                ta_err_o  = rd_q && rise_i && last_bit && mdio_i;
            end
            S_DATA: begin
                mdio_o    = sr_q[SR_W-1];
                mdio_oe_o = !rd_q;
                rd_done_o = rd_q && rise_i && last_bit;
            end
            S_END: mdio_o = 1'b1;
            default: busy_o = 1'b0;
        endcase
    end

    // R9
    mdio_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_i |=> $stable(mdio_o));

    // R5
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && rd_q && !mdio_oe_o) |=> !mdio_oe_o);

    // R10
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (state_q == S_IDLE));

    // R7
    err_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ta_err_o |-> rd_q);

endmodule

// File: rtl/mdio_c45_regs.sv
module mdio_c45_regs
    import mdio_c45_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int DIV_RST = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [1:0]       addr_i,
    input  logic [31:0]      wdata_i,
    output logic [31:0]      rdata_o,
    input  logic             busy_i,
    input  logic             rd_done_i,
    input  logic [15:0]      rd_data_i,
    input  logic             ta_err_i,
    output logic             start_o,
    output op_t              op_o,
    output logic [4:0]       port_o,
    output logic [4:0]       dev_o,
    output logic [15:0]      field_o,
    output logic [DIV_W-1:0] half_o
);

    logic [15:0]      cmd_q;
    logic [15:0]      addr_q;
    logic [15:0]      data_q;
    logic [DIV_W-1:0] div_q;
    logic [6:0]       cfg_q;
    logic             err_q;
    logic             accept;

    assign accept  = we_i && !busy_i;
    assign half_o  = div_q;
    assign field_o = wdata_i[15:0];

    always_comb begin
        start_o = 1'b0;
        op_o    = OP_ADDR;
        port_o  = cmd_q[9:5];
        dev_o   = cmd_q[4:0];
        if (accept) begin
            case (addr_i)
                RA_CMD: begin
                    if (wdata_i[15]) begin
                        start_o = 1'b1;
                        op_o    = OP_READ;
                        port_o  = wdata_i[9:5];
                        dev_o   = wdata_i[4:0];
                    end
                end
                RA_ADDR: begin
                    start_o = 1'b1;
                    op_o    = OP_ADDR;
                end
                RA_DATA: begin
                    start_o = 1'b1;
                    op_o    = OP_WRITE;
                end
                default: start_o = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
            div_q  <= DIV_W'(DIV_RST);
            cfg_q  <= CFG_RST;
            err_q  <= 1'b0;
        end else begin
            if (accept) begin
                case (addr_i)
                    RA_CMD:  cmd_q  <= wdata_i[15:0];
                    RA_ADDR: addr_q <= wdata_i[15:0];
                    RA_DATA: data_q <= wdata_i[15:0];
                    default: begin
                        div_q <= wdata_i[7+:DIV_W];
                        cfg_q <= wdata_i[6:0];
                    end
                endcase
            end
            if (rd_done_i) begin
                data_q <= rd_data_i;
            end
            if (start_o) begin
                err_q <= 1'b0;
            end else if (ta_err_i) begin
                err_q <= 1'b1;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            RA_CMD:  rdata_o[15:0] = cmd_q;
            RA_ADDR: rdata_o[15:0] = addr_q;
            RA_DATA: rdata_o[15:0] = data_q;
            default: begin
                rdata_o[31]        = busy_i;
                rdata_o[30]        = err_q;
                rdata_o[7+:DIV_W]  = div_q;
                rdata_o[6:0]       = cfg_q;
            end
        endcase
    end

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && we_i) |=> ($stable(cmd_q) && $stable(addr_q) && $stable(div_q) && $stable(cfg_q)));

    // R8
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> busy_i);

    // R7
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !err_q);

endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master #(
    parameter int DIV_W   = 8,
    parameter int DIV_RST = 20,
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);
    import mdio_c45_pkg::*;

    logic             busy;
    logic             start;
    op_t              op;
    logic [4:0]       port;
    logic [4:0]       dev;
    logic [15:0]      field;
    logic [DIV_W-1:0] half;
    logic             rise;
    logic             fall;
    logic             rd_done;
    logic [15:0]      rd_data;
    logic             ta_err;
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata;

    mdio_c45_regs #(
        .DIV_W   (DIV_W),
        .DIV_RST (DIV_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (reg_we),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .rdata_o   (reg_rdata),
        .busy_i    (busy),
        .rd_done_i (rd_done),
        .rd_data_i (rd_data),
        .ta_err_i  (ta_err),
        .start_o   (start),
        .op_o      (op),
        .port_o    (port),
        .dev_o     (dev),
        .field_o   (field),
        .half_o    (half)
    );

    mdio_c45_clkgen #(
        .DIV_W (DIV_W)
    ) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy),
        .half_i (half),
        .mdc_o  (mdc),
        .rise_o (rise),
        .fall_o (fall)
    );

    mdio_c45_frame #(
        .PRE_LEN (PRE_LEN)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .op_i      (op),
        .port_i    (port),
        .dev_i     (dev),
        .field_i   (field),
        .rise_i    (rise),
        .fall_i    (fall),
        .mdio_i    (mdio_i),
        .busy_o    (busy),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe),
        .rd_done_o (rd_done),
        .rd_data_o (rd_data),
        .ta_err_o  (ta_err)
    );

endmodule

// File: tb/mdio_c45_master_test.sv
module mdio_c45_master_test;

    localparam int CLK_PERIOD = 10;
    localparam int PRE        = 8;
    localparam int TOT        = PRE + 32;
    localparam int LIMIT      = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    wire  [31:0] reg_rdata;
    wire         mdc;
    wire         mdio_o;
    wire         mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    mdio_c45_master #(
        .DIV_W   (8),
        .DIV_RST (20),
        .PRE_LEN (PRE)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // PHY model and frame capture
    logic           prev_mdc = 1'b0;
    logic           prev_o = 1'b1;
    logic           prev_oe = 1'b0;
    int             nbit = 0;
    int             gap = 0;
    int             last_period = 0;
    logic [TOT-1:0] cap_o = '0;
    logic [TOT-1:0] cap_oe = '0;
    logic [15:0]    resp = '0;
    logic           ta2 = 1'b0;

    function automatic logic phy_bit(int j);
        if (j == PRE + 15) return ta2;
        if (j >= PRE + 16 && j < TOT) return resp[TOT-1-j];
        return 1'b1;
    endfunction

    always @(negedge clk) begin
        gap = gap + 1;
        if (mdio_oe && !prev_oe && nbit != 0 && !(nbit > 0 && nbit < PRE + 14)) begin
            nbit = 0;
            mdio_i = 1'b1;
            cap_o = '0;
            cap_oe = '0;
        end
        if (mdc && !prev_mdc) begin
            if (nbit < TOT) begin
                cap_o[TOT-1-nbit]  = prev_o;
                cap_oe[TOT-1-nbit] = prev_oe;
            end
            last_period = gap;
            gap = 0;
            nbit = nbit + 1;
            mdio_i = phy_bit(nbit);
        end
        prev_mdc = mdc;
        prev_o   = mdio_o;
        prev_oe  = mdio_oe;
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            rd(2'd3, v);
            if (!v[31]) break;
        end
    endtask

    function automatic logic [1:0] op_of(int kind);
        return (kind == 0) ? 2'b00 : (kind == 1) ? 2'b01 : 2'b11;
    endfunction

    // kind: 0 address, 1 write, 2 read
    task automatic frame(int kind, logic [4:0] port, logic [4:0] dev,
                         logic [15:0] val, int div, logic ta_bad);
        logic [31:0]    v;
        logic [TOT-1:0] exp_f;
        logic [TOT-1:0] exp_oe;
        int             half;
        half = (div == 0) ? 1 : div;
        wr(2'd3, (32'(div) << 7) | 32'h48);
        wr(2'd0, {22'd0, port, dev});
        if (kind == 2) begin
            resp = val;
            ta2  = ta_bad;
            wr(2'd0, {16'd0, 1'b1, 5'd0, port, dev});
        end else begin
            wr((kind == 0) ? 2'd1 : 2'd2, {16'hFFFF, val});
        end
        rd(2'd3, v);
        chk("R8 busy after start", 64'(v[31]), 64'd1);
        wait_idle();
        exp_f = {{PRE{1'b1}}, 2'b00, op_of(kind), port, dev, 2'b10, val};
        if (kind == 2) exp_oe = {{(PRE+14){1'b1}}, 18'd0};
        else           exp_oe = {TOT{1'b1}};
        if (kind == 0)      chk("R3 address frame bits", 64'(cap_o & exp_oe), 64'(exp_f & exp_oe));
        else if (kind == 1) chk("R4 write frame bits", 64'(cap_o & exp_oe), 64'(exp_f & exp_oe));
        else                chk("R5 read frame bits", 64'(cap_o & exp_oe), 64'(exp_f & exp_oe));
        chk((kind == 2) ? "R5 read release pattern" : "R3 drive pattern", 64'(cap_oe), 64'(exp_oe));
        chk("R9 mdc period", 64'(last_period), 64'(2 * half));
        chk("R8 idle pins", {62'd0, mdc, mdio_oe}, 64'd0);
        if (kind == 2) begin
            rd(2'd2, v);
            chk("R6 read data", 64'(v), {48'd0, val});
            rd(2'd3, v);
            chk("R7 error flag", 64'(v[30]), 64'(ta_bad));
        end else if (kind == 1) begin
            rd(2'd2, v);
            chk("R4 data readback", 64'(v), {48'd0, val});
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == LIMIT) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog expired actual=%0d expected<%0d", cyc, LIMIT);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] keep_data;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd3, v);
        chk("R1 status reset", 64'(v), 64'((32'd20 << 7) | 32'h48));
        chk("R1 pins reset", {62'd0, mdc, mdio_oe}, 64'd0);

        // R2 control word without read flag
        wr(2'd0, 32'h0000_7EB5);
        rd(2'd0, v);
        chk("R2 control readback", 64'(v), 64'h7EB5);
        rd(2'd3, v);
        chk("R2 no frame started", 64'(v[31]), 64'd0);

        // sweep: dividers 0..3 against all three frame kinds
        for (int d = 0; d < 4; d++) begin
            for (int k = 0; k < 3; k++) begin
                frame(k, 5'(7 * d + 3 * k + 1), 5'(5 * k + d + 2),
                      16'(16'hA5C3 ^ (d * 16'h1357) ^ (k * 16'h0F0F)), d, 1'b0);
            end
        end

        // R7 turnaround error then clear on next start
        frame(2, 5'd9, 5'd4, 16'h1234, 2, 1'b1);
        wr(2'd1, 32'h0000_0055);
        rd(2'd3, v);
        chk("R7 error cleared by start", 64'(v[30]), 64'd0);
        wait_idle();

        // R10 writes while busy are ignored
        rd(2'd2, keep_data);
        wr(2'd3, (32'd2 << 7) | 32'h48);
        wr(2'd0, {22'd0, 5'd17, 5'd6});
        wr(2'd1, 32'h0000_C0DE);
        repeat (20) @(negedge clk);
        wr(2'd1, 32'h0000_BEEF);
        wr(2'd0, {16'd0, 1'b1, 5'd0, 5'd3, 5'd3});
        wr(2'd3, (32'd7 << 7) | 32'h11);
        wr(2'd2, 32'h0000_4321);
        wait_idle();
        chk("R10 frame unchanged", 64'(cap_o),
            64'({{PRE{1'b1}}, 2'b00, 2'b00, 5'd17, 5'd6, 2'b10, 16'hC0DE}));
        rd(2'd1, v);
        chk("R10 address kept", 64'(v), 64'hC0DE);
        rd(2'd0, v);
        chk("R10 control kept", 64'(v), 64'({5'd17, 5'd6}));
        rd(2'd3, v);
        chk("R10 status kept", 64'(v), 64'((32'd2 << 7) | 32'h48));
        rd(2'd2, v);
        chk("R10 data kept", 64'(v), 64'(keep_data));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule